// File: doc/BRIEF.md
# Ring-Read Event Counter Array

This block keeps 64-bit event counts for a many-core model. Every simulated core owns a set of private counters, and a separate group of global counters tracks machine-wide events such as cache hits, misses, writebacks, instructions retired by type and elapsed target cycles. Private events arrive as a single stream, at most one per cycle, tagged with a core number and an event number. Global events arrive as one pulse line per global counter.

The counters are spread over a chain of nodes joined in a ring, so no central multiplexer exists. Each private node holds the counters of a fixed group of cores in a small distributed memory. A single global node holds its counters in flip-flops. The host puts a packet on the ring input, carrying an operation, a node number, a counter index and a 64-bit data field. Each node registers the packet for one cycle before passing it on. The addressed node places the counter value in the data field. The packet comes back at the ring output after one cycle per node.

With the default sizes there are 64 cores, 16 cores per private node, 10 private counters per core and 17 global counters. That gives four private nodes with numbers 0 to 3 and one global node with number 4, so a packet takes five cycles to cross the ring.

Top module: `pc_ring_counters`

## Requirements
- R1: While reset is high and on the first cycle after it, `ring_out_vld` is low, and every counter reads zero after reset.
- R2: A packet presented with `ring_in_vld` high emerges on `ring_out_vld` exactly 5 cycles later (one cycle per node) and not before. Packets may be presented on consecutive cycles and emerge in the same order, one per cycle.
- R3: The opcode, node number and index of every packet leave the ring unchanged.
- R4: A private counter lives on node core/16, at index (core mod 16)*10 + event. A read (opcode 0) to that location returns the number of accepted events for that core and event.
- R5: Global counter g lives on node 4 at index g. It grows by one in each cycle in which `glob_evt[g]` is high. Any number of global counters may grow in the same cycle.
- R6: A clear (opcode 1) returns the value the counter held before the clear. After the clear, the counter reads zero.
- R7: If a clear reaches a counter in the same cycle as an increment of that counter, the clear wins and the counter reads zero afterwards. If a read reaches a counter in the same cycle as an increment, the read returns the value before the increment, and the increment still counts. An increment of a different counter on the same node in the same cycle as a clear is still counted.
- R8: A private event whose event number is 10 or higher changes no counter.
- R9: A packet whose node number matches no node, or whose index is beyond the counters of the addressed node, returns its data field unchanged. A node that is not addressed never alters the data field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_vld | input | 1 | Private event present this cycle |
| evt_core | input | 6 | Core number of the private event |
| evt_idx | input | 4 | Event number of the private event |
| glob_evt | input | 17 | One increment pulse per global counter |
| ring_in_vld | input | 1 | Packet present at ring input |
| ring_in_op | input | 1 | 0 = read, 1 = read and clear |
| ring_in_node | input | 4 | Target node number |
| ring_in_idx | input | 8 | Counter index within the node |
| ring_in_data | input | 64 | Data field of the packet |
| ring_out_vld | output | 1 | Packet present at ring output |
| ring_out_op | output | 1 | Returned opcode |
| ring_out_node | output | 4 | Returned node number |
| ring_out_idx | output | 8 | Returned index |
| ring_out_data | output | 64 | Returned data field (counter value when addressed) |

## Verification
The bound checker watches the ring hop by hop on every cycle. It checks that the valid flag and the packet header advance exactly one node per cycle, that a node leaves the data of foreign packets alone, and that the output stays quiet through reset. The counting itself can only be shown by the bench scenarios: the private address mapping, the dropping of out-of-range event numbers, read-and-clear, and the same-cycle collisions of a clear or read with an increment. The bench checks these against its own count model under random event traffic.

// File: rtl/pc_pkg.sv
package pc_pkg;

  // Ring opcodes: a read returns the value, a clear returns it and zeroes it
  typedef enum logic {
    PC_RD  = 1'b0,
    PC_CLR = 1'b1
  } pc_op_e;

  function automatic int pc_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pc_ring_hop.sv
// One register stage of the ring: forwards the packet and optionally
// replaces its data field with a local counter value.
module pc_ring_hop #(
  parameter int NODE_W = 4,
  parameter int IDX_W  = 8,
  parameter int CW     = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic              in_op,
  input  logic [NODE_W-1:0] in_node,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [CW-1:0]     in_data,
  input  logic              sub_en,
  input  logic [CW-1:0]     sub_data,
  output logic              out_vld,
  output logic              out_op,
  output logic [NODE_W-1:0] out_node,
  output logic [IDX_W-1:0]  out_idx,
  output logic [CW-1:0]     out_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_op   <= 1'b0;
      out_node <= '0;
      out_idx  <= '0;
      out_data <= '0;
    end else begin
      out_vld  <= in_vld;
      out_op   <= in_op;
      out_node <= in_node;
      out_idx  <= in_idx;
      out_data <= sub_en ? sub_data : in_data;
    end
  end

endmodule

// File: rtl/pc_priv_node.sv
// Private-counter node: counters of CPN cores kept in a distributed RAM.
// A flop per entry marks it as zero, so reset and clear never need a
// second RAM write port.
module pc_priv_node
  import pc_pkg::*;
#(
  parameter int CW      = 64,
  parameter int CPN     = 16,
  parameter int N_PRIV  = 10,
  parameter int NODE_ID = 0,
  parameter int NODE_W  = 4,
  parameter int IDX_W   = 8,
  parameter int CORE_W  = 6,
  parameter int EIDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_vld,
  input  logic [CORE_W-1:0] evt_core,
  input  logic [EIDX_W-1:0] evt_idx,
  input  logic              in_vld,
  input  logic              in_op,
  input  logic [NODE_W-1:0] in_node,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [CW-1:0]     in_data,
  output logic              out_vld,
  output logic              out_op,
  output logic [NODE_W-1:0] out_node,
  output logic [IDX_W-1:0]  out_idx,
  output logic [CW-1:0]     out_data
);

  localparam int DEPTH  = CPN * N_PRIV;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int LC_W   = $clog2(CPN);
  localparam int GRP_W  = CORE_W - LC_W;

  logic [CW-1:0]     mem [DEPTH];
  logic [DEPTH-1:0]  zflag;

  logic [LC_W-1:0]   evt_lc;
  logic [GRP_W-1:0]  evt_grp;
  logic [ADDR_W-1:0] evt_addr;
  logic [ADDR_W-1:0] pkt_addr;
  logic              evt_hit;
  logic              pkt_hit;
  logic              clr_now;
  logic              do_inc;
  logic [CW-1:0]     rd_val;
  logic [CW-1:0]     inc_val;

  assign evt_lc   = evt_core[LC_W-1:0];
  assign evt_grp  = evt_core[CORE_W-1:LC_W];
  assign evt_addr = ADDR_W'(int'(evt_lc) * N_PRIV + int'(evt_idx));
  assign evt_hit  = evt_vld && (evt_grp == GRP_W'(NODE_ID)) &&
                    (int'(evt_idx) < N_PRIV);

  assign pkt_addr = in_idx[ADDR_W-1:0];
  assign pkt_hit  = in_vld && (in_node == NODE_W'(NODE_ID)) &&
                    (int'(in_idx) < DEPTH);
  assign clr_now  = pkt_hit && (in_op == PC_CLR);

  // clear beats an increment of the same entry in the same cycle
  assign do_inc   = evt_hit && !(clr_now && (pkt_addr == evt_addr));

  assign rd_val   = zflag[pkt_addr] ? '0 : mem[pkt_addr];
  assign inc_val  = zflag[evt_addr] ? CW'(1) : mem[evt_addr] + CW'(1);

  // single write port, asynchronous reads: distributed RAM
  always_ff @(posedge clk) begin
    if (do_inc) mem[evt_addr] <= inc_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      zflag <= '1;
    end else begin
      if (do_inc)  zflag[evt_addr] <= 1'b0;
      if (clr_now) zflag[pkt_addr] <= 1'b1;
    end
  end

  pc_ring_hop #(
    .NODE_W (NODE_W),
    .IDX_W  (IDX_W),
    .CW     (CW)
  ) u_hop (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .in_op    (in_op),
    .in_node  (in_node),
    .in_idx   (in_idx),
    .in_data  (in_data),
    .sub_en   (pkt_hit),
    .sub_data (rd_val),
    .out_vld  (out_vld),
    .out_op   (out_op),
    .out_node (out_node),
    .out_idx  (out_idx),
    .out_data (out_data)
  );

endmodule

// File: rtl/pc_glob_node.sv
// Global-counter node: every counter in flip-flops, all may count at once.
module pc_glob_node
  import pc_pkg::*;
#(
  parameter int CW      = 64,
  parameter int N_GLOB  = 17,
  parameter int NODE_ID = 4,
  parameter int NODE_W  = 4,
  parameter int IDX_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_GLOB-1:0] glob_evt,
  input  logic              in_vld,
  input  logic              in_op,
  input  logic [NODE_W-1:0] in_node,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [CW-1:0]     in_data,
  output logic              out_vld,
  output logic              out_op,
  output logic [NODE_W-1:0] out_node,
  output logic [IDX_W-1:0]  out_idx,
  output logic [CW-1:0]     out_data
);

  localparam int ADDR_W = (N_GLOB > 1) ? $clog2(N_GLOB) : 1;

  logic [CW-1:0]     cnt [N_GLOB];
  logic [ADDR_W-1:0] pkt_addr;
  logic              pkt_hit;
  logic              clr_now;
  logic [CW-1:0]     rd_val;

  assign pkt_addr = in_idx[ADDR_W-1:0];
  assign pkt_hit  = in_vld && (in_node == NODE_W'(NODE_ID)) &&
                    (int'(in_idx) < N_GLOB);
  assign clr_now  = pkt_hit && (in_op == PC_CLR);
  assign rd_val   = cnt[pkt_addr];

  for (genvar g = 0; g < N_GLOB; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt[g] <= '0;
      end else if (clr_now && (pkt_addr == ADDR_W'(g))) begin
        cnt[g] <= '0;
      end else if (glob_evt[g]) begin
        cnt[g] <= cnt[g] + CW'(1);
      end
    end
  end

  pc_ring_hop #(
    .NODE_W (NODE_W),
    .IDX_W  (IDX_W),
    .CW     (CW)
  ) u_hop (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .in_op    (in_op),
    .in_node  (in_node),
    .in_idx   (in_idx),
    .in_data  (in_data),
    .sub_en   (pkt_hit),
    .sub_data (rd_val),
    .out_vld  (out_vld),
    .out_op   (out_op),
    .out_node (out_node),
    .out_idx  (out_idx),
    .out_data (out_data)
  );

endmodule

// File: rtl/pc_ring_counters.sv
// Event counter array read through a ring of nodes: private nodes first,
// the global node last, ring output taken from the global node.
module pc_ring_counters
  import pc_pkg::*;
#(
  parameter int  CW       = 64,
  parameter int  N_CORES  = 64,
  parameter int  CPN      = 16,
  parameter int  N_PRIV   = 10,
  parameter int  N_GLOB   = 17,
  parameter int  NODE_W   = 4,
  localparam int N_PNODES = N_CORES / CPN,
  localparam int K_NODES  = N_PNODES + 1,
  localparam int CORE_W   = $clog2(N_CORES),
  localparam int EIDX_W   = $clog2(N_PRIV),
  localparam int IDX_W    = $clog2(pc_max(CPN * N_PRIV, N_GLOB))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_vld,
  input  logic [CORE_W-1:0] evt_core,
  input  logic [EIDX_W-1:0] evt_idx,
  input  logic [N_GLOB-1:0] glob_evt,
  input  logic              ring_in_vld,
  input  logic              ring_in_op,
  input  logic [NODE_W-1:0] ring_in_node,
  input  logic [IDX_W-1:0]  ring_in_idx,
  input  logic [CW-1:0]     ring_in_data,
  output logic              ring_out_vld,
  output logic              ring_out_op,
  output logic [NODE_W-1:0] ring_out_node,
  output logic [IDX_W-1:0]  ring_out_idx,
  output logic [CW-1:0]     ring_out_data
);

  // stage i is the input of node i; stage K_NODES is the ring output
  logic [K_NODES:0]             s_vld;
  logic [K_NODES:0]             s_op;
  logic [K_NODES:0][NODE_W-1:0] s_node;
  logic [K_NODES:0][IDX_W-1:0]  s_idx;
  logic [K_NODES:0][CW-1:0]     s_data;

  assign s_vld[0]  = ring_in_vld;
  assign s_op[0]   = ring_in_op;
  assign s_node[0] = ring_in_node;
  assign s_idx[0]  = ring_in_idx;
  assign s_data[0] = ring_in_data;

  for (genvar i = 0; i < N_PNODES; i++) begin : g_pnode
    pc_priv_node #(
      .CW      (CW),
      .CPN     (CPN),
      .N_PRIV  (N_PRIV),
      .NODE_ID (i),
      .NODE_W  (NODE_W),
      .IDX_W   (IDX_W),
      .CORE_W  (CORE_W),
      .EIDX_W  (EIDX_W)
    ) u_node (
      .clk      (clk),
      .rst      (rst),
      .evt_vld  (evt_vld),
      .evt_core (evt_core),
      .evt_idx  (evt_idx),
      .in_vld   (s_vld[i]),
      .in_op    (s_op[i]),
      .in_node  (s_node[i]),
      .in_idx   (s_idx[i]),
      .in_data  (s_data[i]),
      .out_vld  (s_vld[i+1]),
      .out_op   (s_op[i+1]),
      .out_node (s_node[i+1]),
      .out_idx  (s_idx[i+1]),
      .out_data (s_data[i+1])
    );
  end

  pc_glob_node #(
    .CW      (CW),
    .N_GLOB  (N_GLOB),
    .NODE_ID (N_PNODES),
    .NODE_W  (NODE_W),
    .IDX_W   (IDX_W)
  ) u_glob (
    .clk      (clk),
    .rst      (rst),
    .glob_evt (glob_evt),
    .in_vld   (s_vld[N_PNODES]),
    .in_op    (s_op[N_PNODES]),
    .in_node  (s_node[N_PNODES]),
    .in_idx   (s_idx[N_PNODES]),
    .in_data  (s_data[N_PNODES]),
    .out_vld  (s_vld[K_NODES]),
    .out_op   (s_op[K_NODES]),
    .out_node (s_node[K_NODES]),
    .out_idx  (s_idx[K_NODES]),
    .out_data (s_data[K_NODES])
  );

  assign ring_out_vld  = s_vld[K_NODES];
  assign ring_out_op   = s_op[K_NODES];
  assign ring_out_node = s_node[K_NODES];
  assign ring_out_idx  = s_idx[K_NODES];
  assign ring_out_data = s_data[K_NODES];

endmodule

// File: rtl/pc_ring_counters_chk.sv
// Hop-level ring checks, bound into the top module.
module pc_ring_counters_chk #(
  parameter int K      = 5,
  parameter int NODE_W = 4,
  parameter int IDX_W  = 8,
  parameter int CW     = 64
) (
  input logic                   clk,
  input logic                   rst,
  input logic [K:0]             vld_s,
  input logic [K:0]             op_s,
  input logic [K:0][NODE_W-1:0] node_s,
  input logic [K:0][IDX_W-1:0]  idx_s,
  input logic [K:0][CW-1:0]     data_s
);

  logic up;
  always_ff @(posedge clk) begin
    if (rst) up <= 1'b0;
    else     up <= 1'b1;
  end

  // R1: output stays quiet through reset
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !vld_s[K]);

  for (genvar i = 0; i < K; i++) begin : g_hop
    // R2: valid advances exactly one node per cycle
    a_r2_hop_delay: assert property (@(posedge clk) disable iff (rst)
      up |-> (vld_s[i+1] == $past(vld_s[i])));

    // R3: header carried unchanged through each node
    a_r3_header_kept: assert property (@(posedge clk) disable iff (rst)
      (up && vld_s[i+1]) |-> (op_s[i+1] == $past(op_s[i]) &&
                              node_s[i+1] == $past(node_s[i]) &&
                              idx_s[i+1] == $past(idx_s[i])));

    // R9: a node leaves the data of packets addressed elsewhere alone
    a_r9_foreign_data_kept: assert property (@(posedge clk) disable iff (rst)
      (up && vld_s[i+1] && node_s[i+1] != NODE_W'(i)) |->
        (data_s[i+1] == $past(data_s[i])));
  end

endmodule

bind pc_ring_counters pc_ring_counters_chk #(
  .K      (K_NODES),
  .NODE_W (NODE_W),
  .IDX_W  (IDX_W),
  .CW     (CW)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .vld_s  (s_vld),
  .op_s   (s_op),
  .node_s (s_node),
  .idx_s  (s_idx),
  .data_s (s_data)
);

// File: tb/pc_ring_counters_bench.sv
module pc_ring_counters_bench;

  localparam int CLK_PERIOD = 10;
  localparam int K   = 5;
  localparam int CPN = 16;
  localparam int NP  = 10;
  localparam int NG  = 17;
  localparam int NC  = 64;
  localparam bit OP_RD  = 1'b0;
  localparam bit OP_CLR = 1'b1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_vld = 1'b0;
  logic [5:0]  evt_core = '0;
  logic [3:0]  evt_idx = '0;
  logic [16:0] glob_evt = '0;
  logic        ring_in_vld = 1'b0;
  logic        ring_in_op = 1'b0;
  logic [3:0]  ring_in_node = '0;
  logic [7:0]  ring_in_idx = '0;
  logic [63:0] ring_in_data = '0;
  logic        ring_out_vld;
  logic        ring_out_op;
  logic [3:0]  ring_out_node;
  logic [7:0]  ring_out_idx;
  logic [63:0] ring_out_data;

  pc_ring_counters u_pc_ring_counters (
    .clk(clk), .rst(rst), .evt_vld(evt_vld), .evt_core(evt_core),
    .evt_idx(evt_idx), .glob_evt(glob_evt), .ring_in_vld(ring_in_vld),
    .ring_in_op(ring_in_op), .ring_in_node(ring_in_node),
    .ring_in_idx(ring_in_idx), .ring_in_data(ring_in_data),
    .ring_out_vld(ring_out_vld), .ring_out_op(ring_out_op),
    .ring_out_node(ring_out_node), .ring_out_idx(ring_out_idx),
    .ring_out_data(ring_out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  longint unsigned pm [NC][NP];
  longint unsigned gm [NG];

  task automatic chk(input string req, input longint unsigned act,
                     input longint unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] pnode(input int core);
    return 4'(core / CPN);
  endfunction

  function automatic logic [7:0] pidx(input int core, input int evt);
    return 8'((core % CPN) * NP + evt);
  endfunction

  task automatic quiet();
    evt_vld = 1'b0;
    glob_evt = '0;
    ring_in_vld = 1'b0;
  endtask

  // drive one event cycle and update the model
  task automatic ev(input bit v, input int core, input int evt,
                    input logic [16:0] gmask);
    @(negedge clk);
    ring_in_vld = 1'b0;
    evt_vld = v;
    evt_core = 6'(core);
    evt_idx = 4'(evt);
    glob_evt = gmask;
    if (v && evt < NP) pm[core][evt]++;
    for (int g = 0; g < NG; g++) if (gmask[g]) gm[g]++;
  endtask

  // one packet around the ring, with latency and header checks
  task automatic xfer(input bit op, input logic [3:0] node,
                      input logic [7:0] idx, input logic [63:0] din,
                      output longint unsigned dout);
    @(negedge clk);
    evt_vld = 1'b0;
    glob_evt = '0;
    ring_in_vld = 1'b1;
    ring_in_op = op;
    ring_in_node = node;
    ring_in_idx = idx;
    ring_in_data = din;
    @(negedge clk);
    ring_in_vld = 1'b0;
    repeat (K-2) @(negedge clk);
    chk("R2 not early", 64'(ring_out_vld), 64'd0);
    @(negedge clk);
    chk("R2 arrival", 64'(ring_out_vld), 64'd1);
    chk("R3 op", 64'(ring_out_op), 64'(op));
    chk("R3 node", 64'(ring_out_node), 64'(node));
    chk("R3 idx", 64'(ring_out_idx), 64'(idx));
    dout = ring_out_data;
  endtask

  task automatic rd(input logic [3:0] node, input logic [7:0] idx,
                    input longint unsigned exp, input string req);
    longint unsigned d;
    xfer(OP_RD, node, idx, 64'hA5A5_A5A5_A5A5_A5A5, d);
    chk(req, d, exp);
  endtask

  // packet plus an event that reaches the addressed node in the same cycle
  task automatic coll(input bit op, input logic [3:0] node, input logic [7:0] idx,
                      input int core, input int evt, input int gbit,
                      output longint unsigned dout);
    for (int c = 0; c < K; c++) begin
      @(negedge clk);
      ring_in_vld = (c == 0);
      ring_in_op = op;
      ring_in_node = node;
      ring_in_idx = idx;
      ring_in_data = 64'h5A5A;
      evt_vld = (c == int'(node)) && (core >= 0);
      evt_core = 6'(core);
      evt_idx = 4'(evt);
      glob_evt = ((c == int'(node)) && (gbit >= 0)) ? 17'(1 << gbit) : '0;
    end
    @(negedge clk);
    quiet();
    chk("R2 collision arrival", 64'(ring_out_vld), 64'd1);
    dout = ring_out_data;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint unsigned d;
    void'($urandom(32'h0BAD_5EED));
    for (int c = 0; c < NC; c++) for (int e = 0; e < NP; e++) pm[c][e] = 0;
    for (int g = 0; g < NG; g++) gm[g] = 0;

    // R1 reset state
    repeat (4) @(negedge clk);
    chk("R1 out quiet in reset", 64'(ring_out_vld), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 out quiet after reset", 64'(ring_out_vld), 64'd0);
    rd(4'd0, 8'd0, 0, "R1 zero core0");
    rd(4'd3, 8'd159, 0, "R1 zero core63 evt9");
    rd(4'd4, 8'd0, 0, "R1 zero glob0");
    rd(4'd4, 8'd16, 0, "R1 zero glob16");

    // R4 private mapping
    repeat (3) ev(1, 5, 3, '0);
    ev(1, 63, 9, '0);
    ev(1, 20, 0, '0);
    ev(1, 20, 0, '0);
    rd(pnode(5), pidx(5, 3), 3, "R4 core5 evt3");
    rd(pnode(63), pidx(63, 9), 1, "R4 core63 evt9");
    rd(pnode(20), pidx(20, 0), 2, "R4 core20 evt0");

    // R8 out-of-range event numbers must not alias onto neighbours
    ev(1, 5, 10, '0);
    ev(1, 5, 15, '0);
    rd(pnode(6), pidx(6, 0), 0, "R8 alias core6 evt0");
    rd(pnode(6), pidx(6, 5), 0, "R8 alias core6 evt5");
    rd(pnode(5), pidx(5, 9), 0, "R8 core5 evt9");

    // R5 global counters, several at once
    repeat (4) ev(0, 0, 0, 17'h00004);
    ev(0, 0, 0, 17'h1FFFF);
    rd(4'd4, 8'd2, 5, "R5 glob2");
    rd(4'd4, 8'd16, 1, "R5 glob16");
    rd(4'd4, 8'd0, 1, "R5 glob0");

    // R6 read and clear
    xfer(OP_CLR, pnode(5), pidx(5, 3), 64'h0, d);
    chk("R6 clear returns old core5", d, 3);
    pm[5][3] = 0;
    rd(pnode(5), pidx(5, 3), 0, "R6 zero after clear");
    xfer(OP_CLR, 4'd4, 8'd2, 64'h0, d);
    chk("R6 clear returns old glob2", d, 5);
    gm[2] = 0;
    rd(4'd4, 8'd2, 0, "R6 glob2 zero");

    // R7 same-cycle collisions
    coll(OP_CLR, pnode(20), pidx(20, 0), 20, 0, -1, d);
    chk("R7 clear vs inc returns old", d, 2);
    pm[20][0] = 0;
    rd(pnode(20), pidx(20, 0), 0, "R7 clear wins private");
    coll(OP_RD, pnode(20), pidx(20, 0), 20, 0, -1, d);
    chk("R7 read sees pre-increment", d, 0);
    pm[20][0] = 1;
    rd(pnode(20), pidx(20, 0), 1, "R7 increment kept after read");
    coll(OP_CLR, pnode(20), pidx(20, 0), 21, 0, -1, d);
    chk("R7 clear other entry returns old", d, 1);
    pm[20][0] = 0;
    pm[21][0] = 1;
    rd(pnode(20), pidx(20, 0), 0, "R7 cleared entry");
    rd(pnode(21), pidx(21, 0), 1, "R7 neighbour inc kept");
    coll(OP_CLR, 4'd4, 8'd16, -1, 0, 16, d);
    chk("R7 glob clear returns old", d, 1);
    gm[16] = 0;
    rd(4'd4, 8'd16, 0, "R7 glob clear wins");
    coll(OP_RD, 4'd4, 8'd0, -1, 0, 0, d);
    chk("R7 glob read pre-increment", d, 1);
    gm[0] = 2;
    rd(4'd4, 8'd0, 2, "R7 glob increment kept");

    // R9 unaddressed data passes untouched
    xfer(OP_RD, 4'd7, 8'd0, 64'h1234_5678_9ABC_DEF0, d);
    chk("R9 no such node", d, 64'h1234_5678_9ABC_DEF0);
    xfer(OP_CLR, 4'd0, 8'd200, 64'hFEED_0000_0000_0001, d);
    chk("R9 private index beyond", d, 64'hFEED_0000_0000_0001);
    xfer(OP_RD, 4'd4, 8'd17, 64'h0000_0000_CAFE_0017, d);
    chk("R9 global index beyond", d, 64'h0000_0000_CAFE_0017);

    // R2 back-to-back packets keep order
    for (int p = 0; p < 3; p++) begin
      @(negedge clk);
      ring_in_vld = 1'b1;
      ring_in_op = OP_RD;
      ring_in_node = pnode(63);
      ring_in_idx = 8'(p == 0 ? pidx(63, 9) : pidx(63, p));
      ring_in_data = '0;
    end
    @(negedge clk);
    ring_in_vld = 1'b0;
    repeat (K-4) @(negedge clk);
    chk("R2 burst not early", 64'(ring_out_vld), 64'd0);
    for (int p = 0; p < 3; p++) begin
      @(negedge clk);
      chk("R2 burst valid", 64'(ring_out_vld), 64'd1);
      chk("R2 burst order", 64'(ring_out_idx),
          64'(p == 0 ? pidx(63, 9) : pidx(63, p)));
      chk("R4 burst data", ring_out_data, p == 0 ? pm[63][9] : pm[63][p]);
    end

    // random traffic against the model
    for (int r = 0; r < 3; r++) begin
      for (int n = 0; n < 300; n++) begin
        ev(($urandom % 4) != 0, int'($urandom % NC), int'($urandom % 12),
           17'($urandom & $urandom));
      end
      for (int n = 0; n < 40; n++) begin
        bit clr = ($urandom % 5) == 0;
        if (($urandom % 3) == 0) begin
          int g = int'($urandom % NG);
          xfer(clr, 4'd4, 8'(g), '0, d);
          chk("R5 random glob", d, gm[g]);
          if (clr) gm[g] = 0;
        end else begin
          int c = int'($urandom % NC);
          int e = int'($urandom % NP);
          xfer(clr, pnode(c), pidx(c, e), '0, d);
          chk("R4 random private", d, pm[c][e]);
          if (clr) pm[c][e] = 0;
        end
      end
    end

    quiet();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule